// File: doc/BRIEF.md
# SMBus Byte-Register Slave

This block is the serial control port of a bus-switch style device. A host on a two-wire bus reads and writes four 8-bit registers through it using the SMBus Write Byte and Read Byte protocols. Register 0 is a read-only status byte supplied from outside. Registers 1 to 3 are writable control bytes. The block also answers the SMBus Alert Response Address by returning its own address.

SCL and SDA arrive as raw samples. Each passes through a synchronizer and a stability filter before START, repeated START and STOP are detected. The 7-bit device address is a fixed `10` prefix followed by five strap bits. A Write Byte only takes effect when its STOP arrives, so a transfer that is broken off by a repeated START leaves every register untouched.

The block also accepts a broadcast write address, which software can mask. A write to the status register changes no register and instead pulses a fault-clear strobe. While the enable input is low, the block ignores the bus and holds every register at its default.

Top module: `smb_regslave`

## Requirements
- R1: The device address is {1, 0, strap_i[4:0]}. An address byte carries the address in bits 7..1 and R/W in bit 0, where 0 means write. The slave ACKs its own address and NACKs any address it does not serve.
- R2: In the command byte only bits 1..0 select the register, numbered 0 to 3. Bits 7..2 have no effect.
- R3: A Write Byte to register n (1..3) updates only at the STOP that follows the data byte. The write shows as a one-cycle pulse on wr_stb_o[n-1] in the same cycle that regn_o changes. No register changes at any other time except the enable clear.
- R4: If a repeated START arrives after the data byte and before STOP, the pending write is discarded and every register keeps its value.
- R5: A Read Byte returns the selected register in a single byte, MSB first. Register 0 reads as status_i.
- R6: Write transfers to address 0x5E (binary 1011110) are accepted only while bit 2 of register 2 is 1, and they act like writes to the own address. Read transfers to 0x5E are always NACKed. Register 2 resets to 0x04.
- R7: A read to 0x0C (binary 0001100) while alert_i is 1 is ACKed, and the slave returns {own address, 0}. While alert_i is 0 that address is NACKed.
- R8: While enable_i is low, registers 1..3 go to 0x00, 0x04 and 0x00, SDA is released, no strobe fires, and bus traffic is not answered.
- R9: A write to register 0 changes no register and gives one fault_clr_o pulse at STOP. At most one strobe fires in any cycle.
- R10: A pulse on SCL or SDA that is shorter than FILT_N clock cycles (default 6, which is 60 ns at 100 MHz) does not reach the protocol logic.
- R11: After reset, sda_pull_o, all strobes and registers 1 and 3 are 0, and register 2 is 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | High to serve the bus; low clears registers and ignores traffic |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level |
| strap_i | input | 5 | Low five bits of the device address |
| alert_i | input | 1 | High while this device is asserting ALERT |
| status_i | input | 8 | Value returned when register 0 is read |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| reg1_o | output | 8 | Control register 1 |
| reg2_o | output | 8 | Control register 2 (bit 2 enables mass write) |
| reg3_o | output | 8 | Control register 3 |
| wr_stb_o | output | 3 | One-cycle write strobes for registers 1..3 |
| fault_clr_o | output | 1 | One-cycle pulse on a write to register 0 |

## Verification
Random Write Byte and Read Byte pairs are used with random register numbers, random data and random don't-care command bits. Reading each write back shows whether the register select and the data path agree, and whether the upper command bits really have no effect. Directed transfers then target one rule at a time: a foreign address, a break-off by repeated START, a mass write with the enable set and then cleared, a mass-address read, the alert address with alert_i low and then high, and a write to the status register. Each of these has a visible result that differs from a plain write. An SCL spike inserted inside a data bit would add a bit and corrupt the written byte if the filter let it through. Traffic sent while enable is low must get no ACK and leave the defaults in place.

// File: rtl/smb_pkg.sv
// Shared types and fixed codes of the SMBus register slave.
package smb_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_SKIP
    } smb_state_e;

    typedef enum logic [1:0] {
        K_ADDR, K_CMD, K_DATA
    } smb_kind_e;

    localparam logic [6:0] ARA_ADDR  = 7'h0C;
    localparam logic [6:0] MASS_ADDR = 7'h5E;
    localparam int         MWE_BIT   = 2;
endpackage

// File: rtl/smb_glitch_filter.sv
// Two-flop synchronizer followed by a stability counter.
// The output takes a new level only after the synchronized input has
// differed from it for CNT_N consecutive clocks. Idle level is 1.
module smb_glitch_filter #(
    parameter int CNT_N = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(CNT_N + 1);

    logic         s1, s2;
    logic [CW-1:0] cnt;

    // synchronize the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    // accept a level only after CNT_N stable samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
            cnt  <= '0;
        end else if (s2 == dout) begin
            cnt <= '0;
        end else if (cnt == CW'(CNT_N - 1)) begin
            dout <= s2;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smb_cond_detect.sv
// Detects START, STOP and SCL edges on filtered bus levels.
// Assumes both inputs come from identical filters, so their order is kept.
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // previous filtered levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // bus events from level pairs
    always_comb begin
        start_o = scl_q & scl_f & sda_q & ~sda_f;
        stop_o  = scl_q & scl_f & ~sda_q & sda_f;
        rise_o  = ~scl_q & scl_f;
        fall_o  = scl_q & ~scl_f;
    end
endmodule

// File: rtl/smb_byte_fsm.sv
// Byte-level SMBus slave protocol engine.
// Receives bytes on SCL rise, drives ACK and read data after SCL fall,
// holds a write pending until STOP, and drops it on any START.
module smb_byte_fsm #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         sda_f,
    input  logic [6:0]   own_addr_i,
    input  logic         mwe_i,
    input  logic         alert_i,
    input  logic [W-1:0] rdata_i,
    output logic         sda_pull_o,
    output logic [AW-1:0] rsel_o,
    output logic         commit_o,
    output logic [AW-1:0] commit_idx_o,
    output logic [W-1:0] commit_data_o
);
    import smb_pkg::*;

    localparam int BW = $clog2(W + 1);

    smb_state_e    st;
    smb_kind_e     kind;
    logic [BW-1:0] bitcnt;
    logic [W-1:0]  sh;
    logic [W-1:0]  txb;
    logic          go_tx;
    logic          pend_v;
    logic [AW-1:0] pend_idx;
    logic [W-1:0]  pend_data;
    logic [AW-1:0] ptr;

    assign rsel_o = ptr;

    // protocol sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st            <= S_IDLE;
            kind          <= K_ADDR;
            bitcnt        <= '0;
            sh            <= '0;
            txb           <= '0;
            go_tx         <= 1'b0;
            pend_v        <= 1'b0;
            pend_idx      <= '0;
            pend_data     <= '0;
            ptr           <= '0;
            sda_pull_o    <= 1'b0;
            commit_o      <= 1'b0;
            commit_idx_o  <= '0;
            commit_data_o <= '0;
        end else begin
            commit_o <= 1'b0;
            if (stop_i) begin
                commit_o      <= pend_v;
                commit_idx_o  <= pend_idx;
                commit_data_o <= pend_data;
                pend_v        <= 1'b0;
                sda_pull_o    <= 1'b0;
                st            <= S_IDLE;
            end else if (start_i) begin
                st         <= S_RX;
                kind       <= K_ADDR;
                bitcnt     <= '0;
                pend_v     <= 1'b0;
                go_tx      <= 1'b0;
                sda_pull_o <= 1'b0;
            end else begin
                case (st)
                    S_RX: begin
                        if (rise_i) begin
                            sh     <= {sh[W-2:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (fall_i && bitcnt == BW'(W)) begin
                            st         <= S_RX_ACK;
                            sda_pull_o <= 1'b1;
                            go_tx      <= 1'b0;
                            case (kind)
                                K_ADDR: begin
                                    if (sh[7:1] == own_addr_i) begin
                                        go_tx <= sh[0];
                                        txb   <= rdata_i;
                                        kind  <= K_CMD;
                                    end else if (!sh[0] && mwe_i && sh[7:1] == MASS_ADDR) begin
                                        kind <= K_CMD;
                                    end else if (sh[0] && alert_i && sh[7:1] == ARA_ADDR) begin
                                        go_tx <= 1'b1;
                                        txb   <= {own_addr_i, 1'b0};
                                    end else begin
                                        st         <= S_SKIP;
                                        sda_pull_o <= 1'b0;
                                    end
                                end
                                K_CMD: begin
                                    ptr  <= sh[AW-1:0];
                                    kind <= K_DATA;
                                end
                                default: begin
                                    pend_v    <= 1'b1;
                                    pend_idx  <= ptr;
                                    pend_data <= sh;
                                end
                            endcase
                        end
                    end
                    S_RX_ACK: begin
                        if (fall_i) begin
                            bitcnt <= '0;
                            if (go_tx) begin
                                st         <= S_TX;
                                sh         <= txb;
                                sda_pull_o <= ~txb[W-1];
                            end else begin
                                st         <= S_RX;
                                sda_pull_o <= 1'b0;
                            end
                        end
                    end
                    S_TX: begin
                        if (rise_i) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (fall_i) begin
                            if (bitcnt == BW'(W)) begin
                                sda_pull_o <= 1'b0;
                                st         <= S_TX_ACK;
                            end else begin
                                sh         <= {sh[W-2:0], 1'b0};
                                sda_pull_o <= ~sh[W-2];
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (fall_i) st <= S_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_regfile.sv
// Register file: index 0 is external read-only status, 1..NREG-1 are
// writable. A commit to index 0 only pulses strobe bit 0.
module smb_regfile #(
    parameter int W    = 8,
    parameter int NREG = 4,
    parameter logic [NREG*W-1:0] RST_VAL = '0,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   commit_i,
    input  logic [AW-1:0]          commit_idx_i,
    input  logic [W-1:0]           commit_data_i,
    input  logic [AW-1:0]          rsel_i,
    input  logic [W-1:0]           status_i,
    output logic [(NREG-1)*W-1:0]  regs_o,
    output logic [NREG-1:0]        stb_o,
    output logic [W-1:0]           rdata_o
);
    for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
        logic [W-1:0] q;
        // hold one writable register
        always_ff @(posedge clk) begin
            if (!rst_n || !en)
                q <= RST_VAL[gi*W +: W];
            else if (commit_i && commit_idx_i == AW'(gi))
                q <= commit_data_i;
        end
        assign regs_o[(gi-1)*W +: W] = q;
    end

    // one-cycle strobe per committed index
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            stb_o <= '0;
        end else begin
            stb_o <= '0;
            if (commit_i) stb_o[commit_idx_i] <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        rdata_o = status_i;
        for (int i = 1; i < NREG; i++)
            if (rsel_i == AW'(i)) rdata_o = regs_o[(i-1)*W +: W];
    end
endmodule

// File: rtl/smb_regslave.sv
// Top: SMBus byte-register slave with filtered inputs, four registers,
// mass-write and alert-response addresses. Inputs are assumed to be
// sampled well above the SCL rate; enable_i is synchronous to clk.
module smb_regslave #(
    parameter int         FILT_N   = 6,
    parameter logic [7:0] REG2_RST = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [4:0] strap_i,
    input  logic       alert_i,
    input  logic [7:0] status_i,
    output logic       sda_pull_o,
    output logic [7:0] reg1_o,
    output logic [7:0] reg2_o,
    output logic [7:0] reg3_o,
    output logic [2:0] wr_stb_o,
    output logic       fault_clr_o
);
    localparam int W    = 8;
    localparam int NREG = 4;
    localparam int AW   = $clog2(NREG);
    localparam logic [NREG*W-1:0] RST_ALL = {8'h00, REG2_RST, 8'h00, 8'h00};

    logic [1:0] raw, filt;
    logic start_evt, stop_evt, rise_evt, fall_evt;
    logic commit;
    logic [AW-1:0] commit_idx, rsel;
    logic [W-1:0]  commit_data, rdata;
    logic [(NREG-1)*W-1:0] regs;
    logic [NREG-1:0] stb;

    assign raw = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_filt
        smb_glitch_filter #(.CNT_N(FILT_N)) u_filt (
            .clk(clk), .rst_n(rst_n), .din(raw[gi]), .dout(filt[gi])
        );
    end

    smb_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(filt[1]), .sda_f(filt[0]),
        .start_o(start_evt), .stop_o(stop_evt), .rise_o(rise_evt), .fall_o(fall_evt)
    );

    smb_byte_fsm #(.W(W), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(enable_i),
        .start_i(start_evt), .stop_i(stop_evt), .rise_i(rise_evt), .fall_i(fall_evt),
        .sda_f(filt[0]), .own_addr_i({2'b10, strap_i}),
        .mwe_i(reg2_o[smb_pkg::MWE_BIT]), .alert_i(alert_i), .rdata_i(rdata),
        .sda_pull_o(sda_pull_o), .rsel_o(rsel), .commit_o(commit),
        .commit_idx_o(commit_idx), .commit_data_o(commit_data)
    );

    smb_regfile #(.W(W), .NREG(NREG), .RST_VAL(RST_ALL), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .en(enable_i), .commit_i(commit),
        .commit_idx_i(commit_idx), .commit_data_i(commit_data),
        .rsel_i(rsel), .status_i(status_i), .regs_o(regs), .stb_o(stb),
        .rdata_o(rdata)
    );

    assign reg1_o      = regs[7:0];
    assign reg2_o      = regs[15:8];
    assign reg3_o      = regs[23:16];
    assign wr_stb_o    = stb[3:1];
    assign fault_clr_o = stb[0];
endmodule

// File: rtl/smb_regslave_chk.sv
// Checker for smb_regslave, attached by bind below.
module smb_regslave_chk #(
    parameter logic [7:0] REG2_RST = 8'h04
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       stop_evt,
    input logic       sda_pull_o,
    input logic [7:0] reg1_o,
    input logic [7:0] reg2_o,
    input logic [7:0] reg3_o,
    input logic [2:0] wr_stb_o,
    input logic       fault_clr_o
);
    p_en_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!sda_pull_o && !fault_clr_o && wr_stb_o == 3'b000));

    p_en_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (reg1_o == 8'h00 && reg2_o == REG2_RST && reg3_o == 8'h00));

    p_commit_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_stb_o) || fault_clr_o) |-> $past(stop_evt, 2));

    p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb_o, fault_clr_o}));

    p_reg1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_i) && !wr_stb_o[0]) |-> $stable(reg1_o));

    p_reg2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_i) && !wr_stb_o[1]) |-> $stable(reg2_o));

    p_reg3_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_i) && !wr_stb_o[2]) |-> $stable(reg3_o));

    p_reg0_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_o |-> ($stable(reg1_o) && $stable(reg2_o) && $stable(reg3_o)));
endmodule

bind smb_regslave smb_regslave_chk #(.REG2_RST(REG2_RST)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .stop_evt(stop_evt),
    .sda_pull_o(sda_pull_o), .reg1_o(reg1_o), .reg2_o(reg2_o), .reg3_o(reg3_o),
    .wr_stb_o(wr_stb_o), .fault_clr_o(fault_clr_o)
);

// File: tb/tb_smb_regslave.sv
// Bit-banged SMBus master bench for smb_regslave.
module tb_smb_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int H = 20;
    localparam int Q = 5;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic alert_i = 1'b0;
    logic [4:0] strap = 5'h0A;
    logic [7:0] status = 8'hA5;
    logic sda_pull, fault_clr;
    logic [7:0] reg1, reg2, reg3;
    logic [2:0] wr_stb;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    smb_regslave dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .alert_i(alert_i), .status_i(status), .sda_pull_o(sda_pull),
        .reg1_o(reg1), .reg2_o(reg2), .reg3_o(reg3), .wr_stb_o(wr_stb), .fault_clr_o(fault_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, fclr_cnt = 0, cycles = 0;
    logic [7:0] mdl [4];
    logic [6:0] own;

    always @(posedge clk) begin
        if (fault_clr) fclr_cnt++;
        cycles++;
        if (cycles > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_read(input logic [1:0] idx);
        return (idx == 2'd0) ? status : mdl[idx];
    endfunction

    function automatic logic [7:0] exp_ara();
        return {own, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_regs(input string req);
        chk(req, {8'h00, reg3, reg2, reg1}, {8'h00, mdl[3], mdl[2], mdl[1]});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        cyc(Q); sda_m = 1'b1; cyc(H - Q);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(Q); sda_m = 1'b0; cyc(H - Q);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b1; cyc(2*H);
    endtask

    // gl: bit index that receives a short SCL spike in its low phase, -1 none
    task automatic wbyte(input logic [7:0] b, input int gl, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            cyc(Q); sda_m = b[i]; cyc(H - Q);
            if (gl == i) begin
                scl_m = 1'b1; cyc(3); scl_m = 1'b0; cyc(H);
            end
            scl_m = 1'b1; cyc(H); scl_m = 1'b0;
        end
        cyc(Q); sda_m = 1'b1; cyc(H - Q);
        scl_m = 1'b1; cyc(H/2); ack = ~sda_line; cyc(H/2); scl_m = 1'b0;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            cyc(Q); sda_m = 1'b1; cyc(H - Q);
            scl_m = 1'b1; cyc(H/2); b[i] = sda_line; cyc(H/2); scl_m = 1'b0;
        end
        cyc(Q); sda_m = nack; cyc(H - Q);
        scl_m = 1'b1; cyc(H); scl_m = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                            input int gl, output logic [2:0] acks);
        bus_start();
        wbyte({a, 1'b0}, -1, acks[2]);
        if (acks[2]) begin
            wbyte(cmd, -1, acks[1]);
            wbyte(d, gl, acks[0]);
        end else acks[1:0] = 2'b00;
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] cmd,
                           output logic ack, output logic [7:0] d);
        logic a0, a1;
        bus_start();
        wbyte({a, 1'b0}, -1, a0);
        wbyte(cmd, -1, a1);
        bus_rstart();
        wbyte({a, 1'b1}, -1, ack);
        if (ack) rbyte(1'b1, d); else d = 8'h00;
        bus_stop();
    endtask

    task automatic do_ara(output logic ack, output logic [7:0] d);
        bus_start();
        wbyte({7'h0C, 1'b1}, -1, ack);
        if (ack) rbyte(1'b1, d); else d = 8'h00;
        bus_stop();
    endtask

    initial begin
        logic [2:0] acks;
        logic ack, a0, a1, a2;
        logic [7:0] d;
        int fc;
        void'($urandom(32'd20240611));
        own = {2'b10, strap};
        mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'h04; mdl[3] = 8'h00;
        cyc(5); rst_n = 1'b1; cyc(3);

        // R11 reset state
        chk("R11 pull", {31'd0, sda_pull}, 32'd0);
        chk("R11 strobes", {28'd0, wr_stb, fault_clr}, 32'd0);
        chk_regs("R11 regs");

        // R1 R2 R3 R5: random write then read back
        for (int it = 0; it < 20; it++) begin
            logic [1:0] idx;
            logic [7:0] dat, up;
            idx = 2'($urandom_range(1, 3));
            dat = 8'($urandom);
            if (idx == 2'd2) dat[2] = 1'b1;
            up  = 8'($urandom);
            do_write(own, {up[5:0], idx}, dat, -1, acks);
            chk("R1 own address write acks", {29'd0, acks}, 32'd7);
            mdl[idx] = dat;
            chk_regs("R3 write at stop");
            up = 8'($urandom);
            do_read(own, {up[7:2], idx}, ack, d);
            chk("R2 R5 read back", {23'd0, ack, d}, {23'd0, 1'b1, exp_read(idx)});
        end

        // R5 status register read
        do_read(own, 8'hFC, ack, d);
        chk("R5 status read", {23'd0, ack, d}, {23'd0, 1'b1, exp_read(2'd0)});

        // R1 foreign address
        do_write(7'h33, 8'h01, 8'h99, -1, acks);
        chk("R1 foreign nack", {29'd0, acks}, 32'd0);
        chk_regs("R1 foreign no change");

        // R4 repeated START after data drops the write
        bus_start();
        wbyte({own, 1'b0}, -1, a0);
        wbyte(8'h01, -1, a1);
        wbyte(~mdl[1], -1, a2);
        bus_rstart();
        bus_stop();
        chk("R4 abort acks", {29'd0, a0, a1, a2}, 32'd7);
        chk_regs("R4 abort no change");

        // R9 write to register 0
        fc = fclr_cnt;
        do_write(own, 8'h00, 8'hFF, -1, acks);
        cyc(5);
        chk("R9 fault clear pulse", fclr_cnt - fc, 32'd1);
        chk_regs("R9 no register change");

        // R10 SCL spike inside a data bit is filtered
        do_write(own, 8'h03, 8'h5A, 3, acks);
        mdl[3] = 8'h5A;
        chk_regs("R10 spike rejected");

        // R6 mass write enabled
        do_write(own, 8'h02, 8'h04, -1, acks); mdl[2] = 8'h04;
        do_write(7'h5E, 8'h01, 8'h3C, -1, acks);
        chk("R6 mass acks", {29'd0, acks}, 32'd7);
        mdl[1] = 8'h3C;
        chk_regs("R6 mass write lands");
        do_read(7'h5E, 8'h01, ack, d);
        chk("R6 mass read nack", {31'd0, ack}, 32'd0);
        do_write(own, 8'h02, 8'h00, -1, acks); mdl[2] = 8'h00;
        do_write(7'h5E, 8'h01, 8'hC3, -1, acks);
        chk("R6 mass masked nack", {29'd0, acks}, 32'd0);
        chk_regs("R6 mass masked no change");

        // R7 alert response
        alert_i = 1'b0;
        do_ara(ack, d);
        chk("R7 ara no alert nack", {31'd0, ack}, 32'd0);
        alert_i = 1'b1;
        do_ara(ack, d);
        chk("R7 ara reply", {23'd0, ack, d}, {23'd0, 1'b1, exp_ara()});
        alert_i = 1'b0;

        // R8 enable low clears and ignores
        enable_i = 1'b0; cyc(5);
        mdl[1] = 8'h00; mdl[2] = 8'h04; mdl[3] = 8'h00;
        chk_regs("R8 defaults");
        do_write(own, 8'h01, 8'h77, -1, acks);
        chk("R8 ignored nack", {29'd0, acks}, 32'd0);
        chk_regs("R8 still defaults");
        chk("R8 pull released", {31'd0, sda_pull}, 32'd0);
        enable_i = 1'b1; cyc(5);
        do_write(own, 8'h01, 8'h81, -1, acks);
        mdl[1] = 8'h81;
        chk_regs("R8 back in service");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule